// File: doc/BRIEF.md
# Memory Range Signature Engine

This block compresses a contiguous range of a 128-bit-wide memory into a single 128-bit signature. Each memory row is 16 bytes. Software names the first and last rows as 17-bit row indices, equal to byte address bits [20:4]. It then sets a go bit, and the engine walks the range through a synchronous memory read port. Each returned row is folded into a 128-bit multiple-input signature register.

When the last row has been folded in, a sticky done flag is raised. Software reads the result as four 32-bit words and acknowledges completion through a separate write-one-to-clear register. A small word-addressed register port carries every control and status access. The memory array and any bus fabric sit outside the block.

Top module: `mem_sig_engine`

## Requirements
- R1: After reset, the first-row register (index 0), the last-row register (index 1), all four result words (indices 2 to 5) and the status register (index 6) read as zero.
- R2: Register index 0 holds the first row in bits [16:0]. Register index 1 holds the last row in bits [16:0], and bit 17 is the go bit. Writing 1 to bit 17 requests a run, and bit 17 reads 1 while a run is in progress and 0 when stopped.
- R3: A run asserts `memRdEn` for exactly one cycle per row, with `memRdAddr` starting at the first row and rising by one each cycle through the last row, both rows included. The memory returns data one cycle after the read.
- R4: If the last row is less than the first row, only the first row is read and folded.
- R5: At the start of a run the signature is cleared to zero. For every returned row D, the new signature is (S shifted left by one) XOR (the polynomial taps at bits 29, 27, 2 and 0, applied only when S bit 127 was 1) XOR D. The signature does not change while idle.
- R6: Result word index 2 reads signature bits [31:0], index 3 bits [63:32], index 4 bits [95:64] and index 5 bits [127:96].
- R7: Status bit 0 is the done flag. For a run of N rows started by the write at clock edge E0, it reads 0 after edge E0+N and reads 1 after edge E0+N+1.
- R8: Writing 1 to bit 0 of register index 7 clears the done flag. Writing 0 there leaves it unchanged, and starting a new run also clears it.
- R9: A go request made while a run is in progress is ignored: the run keeps its range, its length and its result.
- R10: While a run is in progress, the result words show the intermediate signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | 17 | Memory row index |
| memRdData | input | 128 | Memory row data, valid one cycle after the request |

## Verification
A wrong internal state surfaces at the ports in one of two ways. A bad row cursor or end compare shows within one cycle as a wrong `memRdAddr` or a wrong read count. A fault in the compressor or its clear survives into every later result word, because each fold depends on the previous value. Done timing is sampled on both sides of the exact expected edge, so a flag that is one cycle early or late is reported. Runs that are ignored or overlapped are judged by their final signature and read count, so a leaked range change shows up at the end of that run.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int ROW_W  = 17;
  localparam int SIG_W  = 128;
  localparam int WORD_W = 32;
  localparam int REG_AW = 3;
  localparam int NUM_WORDS = SIG_W / WORD_W;
  localparam int GO_BIT = ROW_W;

  localparam logic [REG_AW-1:0] ADDR_FIRST  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_LAST   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_WORD0  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_CLEAR  = 3'd7;

  typedef struct packed {
    logic clear;
    logic fold;
  } sig_strobe_t;
endpackage

// File: rtl/sig_ctrl.sv
module sig_ctrl
  import sig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [ROW_W-1:0]  firstRow,
  output logic [ROW_W-1:0]  lastRow,
  output logic              busy,
  output logic              done,
  output logic              memRdEn,
  output logic [ROW_W-1:0]  memRdAddr,
  output sig_strobe_t       strobe
);
  logic [ROW_W-1:0] firstQ, lastQ, cursorQ, endQ;
  logic busyQ, issueQ, validQ, tailQ, doneQ;
  logic goReq, clrReq, finish, atEnd;
  logic [ROW_W-1:0] lastIn;

  assign lastIn = regWrData[ROW_W-1:0];
  assign goReq  = regWrEn && (regAddr == ADDR_LAST) && regWrData[GO_BIT] && !busyQ;
  assign clrReq = regWrEn && (regAddr == ADDR_CLEAR) && regWrData[0];
  assign atEnd  = (cursorQ == endQ);
  assign finish = validQ && tailQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ <= '0;
      lastQ  <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_FIRST) firstQ <= regWrData[ROW_W-1:0];
      if (regAddr == ADDR_LAST)  lastQ  <= lastIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      issueQ  <= 1'b0;
      cursorQ <= '0;
      endQ    <= '0;
    end else if (goReq) begin
      busyQ   <= 1'b1;
      issueQ  <= 1'b1;
      cursorQ <= firstQ;
      endQ    <= (lastIn < firstQ) ? firstQ : lastIn;
    end else begin
      if (issueQ) begin
        cursorQ <= cursorQ + 1'b1;
        if (atEnd) issueQ <= 1'b0;
      end
      if (finish) busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      tailQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      validQ <= issueQ;
      tailQ  <= issueQ && atEnd;
      if (finish)                doneQ <= 1'b1;
      else if (goReq || clrReq)  doneQ <= 1'b0;
    end
  end

  assign firstRow     = firstQ;
  assign lastRow      = lastQ;
  assign busy         = busyQ;
  assign done         = doneQ;
  assign memRdEn      = issueQ;
  assign memRdAddr    = cursorQ;
  assign strobe.clear = goReq;
  assign strobe.fold  = validQ;
endmodule

// File: rtl/sig_datapath.sv
module sig_datapath
  import sig_pkg::*;
#(
  parameter logic [SIG_W-1:0] TAPS = 128'h0000_0000_0000_0000_0000_0000_2800_0005
)(
  input  logic              clk,
  input  logic              rstN,
  input  sig_strobe_t       strobe,
  input  logic [SIG_W-1:0]  rowData,
  output logic [SIG_W-1:0]  sigValue,
  output logic [WORD_W-1:0] sigWords [NUM_WORDS]
);
  logic [SIG_W-1:0] sigQ, sigNext;

  assign sigNext = {sigQ[SIG_W-2:0], 1'b0}
                 ^ ({SIG_W{sigQ[SIG_W-1]}} & TAPS)
                 ^ rowData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sigQ <= '0;
    else if (strobe.clear) sigQ <= '0;
    else if (strobe.fold)  sigQ <= sigNext;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign sigWords[w] = sigQ[w*WORD_W +: WORD_W];
  end

  assign sigValue = sigQ;
endmodule

// File: rtl/mem_sig_engine.sv
module mem_sig_engine
  import sig_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  output logic                memRdEn,
  output logic [ROW_W-1:0]    memRdAddr,
  input  logic [SIG_W-1:0]    memRdData
);
  sig_strobe_t      strobe;
  logic [ROW_W-1:0] firstRow, lastRow;
  logic             busy, done;
  logic [SIG_W-1:0] sigValue;
  logic [WORD_W-1:0] sigWords [NUM_WORDS];

  sig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .firstRow(firstRow), .lastRow(lastRow),
    .busy(busy), .done(done), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .strobe(strobe)
  );

  sig_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowData(memRdData),
    .sigValue(sigValue), .sigWords(sigWords)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_FIRST:  regRdData[ROW_W-1:0] = firstRow;
      ADDR_LAST:   begin
        regRdData[ROW_W-1:0] = lastRow;
        regRdData[GO_BIT]    = busy;
      end
      ADDR_STATUS: regRdData[0] = done;
      default: begin
        if (regAddr >= ADDR_WORD0 && regAddr < ADDR_WORD0 + NUM_WORDS)
          regRdData = sigWords[regAddr - ADDR_WORD0];
      end
    endcase
  end
endmodule

// File: rtl/mem_sig_engine_chk.sv
module mem_sig_engine_chk
  import sig_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic [WORD_W-1:0] regWrData,
  input logic              memRdEn,
  input logic [ROW_W-1:0]  memRdAddr,
  input logic              busy,
  input logic              done,
  input logic [SIG_W-1:0]  sigValue
);
  AST_RD_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) |-> memRdAddr == $past(memRdAddr) + 1'b1); // R3
  AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdEn); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7
  AST_DONE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(regWrEn) &&
      (($past(regAddr) == ADDR_CLEAR && $past(regWrData[0])) ||
       ($past(regAddr) == ADDR_LAST && $past(regWrData[GO_BIT])))); // R8
  AST_SIG_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(sigValue)); // R5
endmodule

bind mem_sig_engine mem_sig_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .busy(busy), .done(done), .sigValue(sigValue)
);

// File: tb/mem_sig_engine_tb.sv
module mem_sig_engine_tb;
  logic         clk = 0;
  logic         rstN = 0;
  logic [2:0]   regAddr = '0;
  logic         regWrEn = 0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         memRdEn;
  logic [16:0]  memRdAddr;
  logic [127:0] memRdData = '0;

  int checks = 0, errors = 0;
  logic [31:0] salt = 32'h1234_5678;
  int rdCount = 0;
  logic [16:0] rdFirst, rdLast;

  always #10 clk = ~clk;

  mem_sig_engine u_dut (.*);

  function automatic logic [127:0] memRow(input logic [16:0] a, input logic [31:0] s);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = ({15'h0, a} * 32'h9E37_79B1) ^ s ^ (i * 32'h85EB_CA6B);
      w = w ^ (w >> 13) ^ (w << 7);
      r[i*32 +: 32] = w;
    end
    return r;
  endfunction

  function automatic logic [127:0] misrStep(input logic [127:0] s, input logic [127:0] d);
    logic [127:0] t;
    t = s << 1;
    if (s[127]) begin
      t[29] = ~t[29]; t[27] = ~t[27]; t[2] = ~t[2]; t[0] = ~t[0];
    end
    return t ^ d;
  endfunction

  function automatic logic [127:0] expSig(input logic [16:0] f, input logic [16:0] l, input int limit);
    logic [127:0] s = '0;
    logic [16:0] e = (l < f) ? f : l;
    int n = 0;
    for (logic [17:0] a = {1'b0, f}; a <= {1'b0, e} && n < limit; a++) begin
      s = misrStep(s, memRow(a[16:0], salt));
      n++;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memRow(memRdAddr, salt);
      if (rdCount == 0) rdFirst <= memRdAddr;
      rdLast  <= memRdAddr;
      rdCount <= rdCount + 1;
    end
  end

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(posedge clk); @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic rdSig(output logic [127:0] s);
    logic [31:0] v;
    for (int w = 0; w < 4; w++) begin
      rd(3'(2 + w), v); s[w*32 +: 32] = v;
    end
  endtask

  task automatic runCheck(input logic [16:0] f, input logic [16:0] l, input string req);
    logic [31:0] v;
    logic [127:0] s;
    int n;
    logic [16:0] e = (l < f) ? f : l;
    n = int'(e) - int'(f) + 1;
    wr(3'd0, {15'h0, f});
    rdCount = 0;
    wr(3'd1, {14'h0, 1'b1, l});
    rd(3'd1, v); chk(v[17], 1'b1, "R2 go bit reads busy");
    repeat (n) @(negedge clk);
    rd(3'd6, v); chk(v[0], 1'b0, {"R7 done early ", req});
    @(negedge clk);
    rd(3'd6, v); chk(v[0], 1'b1, {"R7 done on time ", req});
    rd(3'd1, v); chk(v[17], 1'b0, "R2 go bit clear when stopped");
    rdSig(s); chk(s, expSig(f, l, 1 << 20), {"R5 R6 signature ", req});
    chk(rdCount, n, {"R3 read count ", req});
    chk(rdFirst, f, {"R3 first row ", req});
    chk(rdLast, e, {"R3 last row ", req});
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] s;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk(v, 0, "R1 reset value");
    end

    runCheck(17'd5, 17'd9, "R3 basic");
    runCheck(17'd40, 17'd40, "R3 single");
    runCheck(17'd30, 17'd12, "R4 stop below start");
    runCheck(17'h1FFF0, 17'h1FFFF, "R3 top of range");

    // R8 clear behaviour
    wr(3'd7, 32'h0); rd(3'd6, v); chk(v[0], 1'b1, "R8 write 0 no effect");
    wr(3'd7, 32'h1); rd(3'd6, v); chk(v[0], 1'b0, "R8 write 1 clears");
    wr(3'd7, 32'h1); wr(3'd0, 32'd3); wr(3'd1, {14'h0, 1'b1, 17'd3});
    repeat (4) @(negedge clk);
    rd(3'd6, v); chk(v[0], 1'b1, "R8 done set again");
    wr(3'd1, {14'h0, 1'b1, 17'd20});
    rd(3'd6, v); chk(v[0], 1'b0, "R8 start clears done");
    repeat (25) @(negedge clk);

    // R10 intermediate value: two rows folded three edges after go
    wr(3'd0, 32'd100);
    wr(3'd1, {14'h0, 1'b1, 17'd110});
    repeat (3) @(negedge clk);
    rdSig(s); chk(s, expSig(17'd100, 17'd110, 2), "R10 intermediate signature");
    repeat (12) @(negedge clk);

    // R9 go while busy ignored
    wr(3'd0, 32'd10);
    rdCount = 0;
    wr(3'd1, {14'h0, 1'b1, 17'd20});
    wr(3'd1, {14'h0, 1'b1, 17'd50});
    repeat (60) @(negedge clk);
    rdSig(s); chk(s, expSig(17'd10, 17'd20, 1 << 20), "R9 signature unchanged");
    chk(rdCount, 11, "R9 read count unchanged");

    // random runs
    for (int k = 0; k < 20; k++) begin
      logic [16:0] f, l;
      salt = $urandom;
      f = 17'($urandom);
      if (f > 17'h1FF00) f = 17'h1FF00;
      if ($urandom % 5 == 0) l = (f == 0) ? 17'd0 : f - 17'(1 + $urandom % 8);
      else l = f + 17'($urandom % 40);
      runCheck(f, l, "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule